// File: doc/BRIEF.md
# Bidirectional Limit Counter Channel

This block is one counter channel. It counts single-cycle strobes on its primary count input. A direction input, sampled on the same clock edge as the strobe, chooses whether each strobe adds one or subtracts one. The top of the counting range is a programmable limit. A limit of zero selects the full scale of the active width. The active width is either the full 32-bit register or a narrow 16-bit register, and the narrow setting masks the limit as well.

A two-bit mode input selects what happens when the count reaches its range. In wrap mode the count recycles through zero. In clamp mode the count holds at the boundary it reached. It leaves the boundary only when a strobe arrives in the opposite direction, or when a clear is issued. In one-shot mode the channel stops itself at the limit, or on an underflow, and stays stopped until it is cleared.

Sticky overflow and underflow flags report every attempt to step past the range. An enable output shows whether the channel still accepts strobes. The control is a four-state machine:
- RUN is normal counting.
- HOLD_HI is clamped at the top.
- HOLD_LO is clamped at zero.
- HALT is stopped by one-shot mode.

The named transitions are:
- RUN to HOLD_HI on an upward overrun in clamp mode.
- RUN to HOLD_LO on a downward overrun in clamp mode.
- HOLD_HI to RUN on a down strobe.
- HOLD_LO to RUN on an up strobe.
- RUN to HALT on reaching the limit or on an overrun in one-shot mode.
- Any state to RUN on clear.

Top module: `ucnt_chan`

## Requirements
- R1: After reset the count is 0, both flags are 0 and the enable output is 1.
- R2: In RUN, each strobe changes the count by one, on the clock edge that samples it. A strobe with direction 0 adds one and a strobe with direction 1 subtracts one. A cycle without a strobe leaves the count unchanged.
- R3: In wrap mode (mode 2'b00, and 2'b11 behaves the same), an up strobe at the top value gives count 0 and sets the overflow flag. A down strobe at 0 gives the top value and sets the underflow flag.
- R4: In clamp mode (mode 2'b01), an up strobe at the top value leaves the count at the top, sets overflow and enters HOLD_HI. A down strobe at 0 leaves the count at 0, sets underflow and enters HOLD_LO. Further strobes in the same direction leave the count unchanged.
- R5: In clamp mode, a strobe in the opposite direction while held steps the count by one away from the boundary and resumes normal counting.
- R6: In one-shot mode (mode 2'b10), an up strobe that makes the count equal to the top value stores that value and drops the enable output to 0. While the enable is 0, strobes in either direction leave the count unchanged.
- R7: In one-shot mode, a down strobe at 0 leaves the count at 0, sets underflow and drops the enable output to 0.
- R8: A clear sets the count to 0, clears both flags and raises the enable output, one cycle later. A clear wins over a strobe in the same cycle.
- R9: The overflow and underflow flags stay set through later counting, and only a clear resets them.
- R10: A limit value of 0 makes the top value the all-ones value of the active width.
- R11: With the narrow width selected, bits 31:16 of the count read 0, the limit is taken from bits 15:0 only, and full scale is 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_stb_i | input | 1 | Count strobe, one count per cycle high |
| cnt_down_i | input | 1 | Direction: 0 up, 1 down |
| clr_i | input | 1 | Clear command |
| mode_i | input | 2 | 00 wrap, 01 clamp, 10 one-shot, 11 wrap |
| narrow_i | input | 1 | 1 selects 16-bit width |
| limit_i | input | 32 | Top value of the range, 0 means full scale |
| count_o | output | 32 | Current count |
| enabled_o | output | 1 | 1 while strobes are accepted |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
A wrong state in the control machine shows up at the next strobe. A channel wrongly left in HOLD_HI or HALT ignores a strobe that should count, so count_o is wrong one cycle after that strobe. A channel that wrongly leaves HALT moves a count that should be frozen. A wrong top value, from the limit decode or from width masking, shows only at the boundary crossing: there the wrap target or the flag is wrong on the cycle after the overrunning strobe. Flag corruption stays visible until the next clear, because the flags are sticky.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;

    typedef enum logic [1:0] {
        MODE_WRAP    = 2'b00,
        MODE_CLAMP   = 2'b01,
        MODE_ONESHOT = 2'b10,
        MODE_SPARE   = 2'b11
    } lim_mode_e;

    typedef enum logic [1:0] {
        ST_RUN     = 2'b00,
        ST_HOLD_HI = 2'b01,
        ST_HOLD_LO = 2'b10,
        ST_HALT    = 2'b11
    } ctr_state_e;

endpackage

// File: rtl/ucnt_bound.sv
// Derives the active-width mask and the top value of the counting range.
module ucnt_bound #(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16
) (
    input  logic             narrow,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] mask,
    output logic [CNT_W-1:0] top
);
    localparam logic [CNT_W-1:0] FULL_MASK   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] NARROW_MASK = FULL_MASK >> (CNT_W - NARROW_W);

    logic [CNT_W-1:0] lim_m;

    always_comb begin
        mask  = narrow ? NARROW_MASK : FULL_MASK;
        lim_m = limit & mask;
        top   = (lim_m == '0) ? mask : lim_m;
    end
endmodule

// File: rtl/ucnt_step.sv
// Arithmetic and boundary detection for the present count.
module ucnt_step #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] mask,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] inc,
    output logic [CNT_W-1:0] dec,
    output logic             at_top,
    output logic             at_zero,
    output logic             reach_top
);
    logic [CNT_W-1:0] cur;

    always_comb begin
        cur       = count & mask;
        inc       = (cur + 1'b1) & mask;
        dec       = (cur - 1'b1) & mask;
        at_top    = (cur >= top);
        at_zero   = (cur == '0);
        reach_top = !at_top && (inc == top);
    end
endmodule

// File: rtl/ucnt_chan.sv
module ucnt_chan
    import ucnt_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_stb_i,
    input  logic             cnt_down_i,
    input  logic             clr_i,
    input  logic [1:0]       mode_i,
    input  logic             narrow_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] count_o,
    output logic             enabled_o,
    output logic             ovf_o,
    output logic             unf_o
);
    ctr_state_e       state_q, state_d;
    lim_mode_e        mode;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ovf_q, ovf_d, unf_q, unf_d;
    logic [CNT_W-1:0] mask, top, inc, dec;
    logic             at_top, at_zero, reach_top;

    assign mode = lim_mode_e'(mode_i);

    ucnt_bound #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_bound (
        .narrow (narrow_i),
        .limit  (limit_i),
        .mask   (mask),
        .top    (top)
    );

    ucnt_step #(.CNT_W(CNT_W)) u_step (
        .count     (cnt_q),
        .mask      (mask),
        .top       (top),
        .inc       (inc),
        .dec       (dec),
        .at_top    (at_top),
        .at_zero   (at_zero),
        .reach_top (reach_top)
    );

    // Next-state and next-data logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q & mask;
        ovf_d   = ovf_q;
        unf_d   = unf_q;
        if (clr_i) begin
            state_d = ST_RUN;
            cnt_d   = '0;
            ovf_d   = 1'b0;
            unf_d   = 1'b0;
        end else if (cnt_stb_i) begin
            unique case (state_q)
                ST_RUN: begin
                    if (!cnt_down_i) begin
                        if (at_top) begin
                            ovf_d = 1'b1;
                            if (mode == MODE_CLAMP) begin
                                state_d = ST_HOLD_HI;
                            end else if (mode == MODE_ONESHOT) begin
                                state_d = ST_HALT;
                            end else begin
                                cnt_d = '0;
                            end
                        end else begin
                            cnt_d = inc;
                            if (mode == MODE_ONESHOT && reach_top) begin
                                state_d = ST_HALT;
                            end
                        end
                    end else begin
                        if (at_zero) begin
                            unf_d = 1'b1;
                            if (mode == MODE_CLAMP) begin
                                state_d = ST_HOLD_LO;
                            end else if (mode == MODE_ONESHOT) begin
                                state_d = ST_HALT;
                            end else begin
                                cnt_d = top;
                            end
                        end else begin
                            cnt_d = dec;
                        end
                    end
                end
                ST_HOLD_HI: begin
                    if (cnt_down_i) begin
                        cnt_d   = dec;
                        state_d = ST_RUN;
                    end
                end
                ST_HOLD_LO: begin
                    if (!cnt_down_i) begin
                        cnt_d   = inc;
                        state_d = ST_RUN;
                    end
                end
                ST_HALT: begin
                    state_d = ST_HALT;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
            ovf_q   <= 1'b0;
            unf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ovf_q   <= ovf_d;
            unf_q   <= unf_d;
        end
    end

    // Outputs
    always_comb begin
        count_o   = cnt_q;
        enabled_o = (state_q != ST_HALT);
        ovf_o     = ovf_q;
        unf_o     = unf_q;
    end

    // R8: clear restarts the channel
    a_r8_clear_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0) && !ovf_o && !unf_o && enabled_o);

    // R6: a stopped channel keeps its count and stays stopped
    a_r6_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled_o && !clr_i && $stable(narrow_i)) |=> $stable(count_o) && !enabled_o);

    // R9: sticky flags
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_i) |=> ovf_o);
    a_r9_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_o && !clr_i) |=> unf_o);

    // R11: narrow width keeps upper bits clear
    a_r11_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
        narrow_i |=> (count_o[CNT_W-1:NARROW_W] == '0));

    // R4: same-direction strobe while clamped at the top keeps the count
    a_r4_clamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD_HI && cnt_stb_i && !cnt_down_i && !clr_i && $stable(narrow_i))
        |=> $stable(count_o));

    // R3: up wrap in wrap mode lands on zero with overflow
    a_r3_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && mode_i == 2'b00 && cnt_stb_i && !cnt_down_i && at_top && !clr_i)
        |=> (count_o == '0) && ovf_o);
endmodule

// File: tb/ucnt_chan_tb.sv
module ucnt_chan_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        stb, dn, clr, narrow;
    logic [1:0]  mode;
    logic [31:0] limit;
    logic [31:0] count;
    logic        en, ovf, unf;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    ucnt_chan u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_stb_i(stb), .cnt_down_i(dn), .clr_i(clr),
        .mode_i(mode), .narrow_i(narrow), .limit_i(limit),
        .count_o(count), .enabled_o(en), .ovf_o(ovf), .unf_o(unf)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive for one clock edge, return at the following negedge
    task automatic pulse(input logic s, input logic d, input logic c);
        stb = s; dn = d; clr = c;
        @(negedge clk);
        stb = 1'b0; dn = 1'b0; clr = 1'b0;
    endtask

    task automatic ups(input int n);
        for (int i = 0; i < n; i++) pulse(1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; stb = 0; dn = 0; clr = 0; narrow = 0; mode = 2'b00; limit = 32'd10;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 count", count, 0);
        check("R1 enable", {31'd0, en}, 1);
        check("R1 flags", {30'd0, ovf, unf}, 0);
    endtask

    task automatic t_basic;
        ups(3);
        check("R2 up", count, 3);
        pulse(1'b1, 1'b1, 1'b0);
        check("R2 down", count, 2);
        pulse(1'b0, 1'b1, 1'b0);
        check("R2 idle", count, 2);
    endtask

    task automatic t_wrap;
        ups(8);
        check("R3 at top", count, 10);
        pulse(1'b1, 1'b0, 1'b0);
        check("R3 wrap up count", count, 0);
        check("R3 wrap up ovf", {31'd0, ovf}, 1);
        ups(2);
        check("R9 ovf sticky", {31'd0, ovf}, 1);
        pulse(1'b1, 1'b0, 1'b1);
        check("R8 clear wins", count, 0);
        check("R8 flags cleared", {30'd0, ovf, unf}, 0);
        mode = 2'b11;
        pulse(1'b1, 1'b1, 1'b0);
        check("R3 wrap down count", count, 10);
        check("R3 wrap down unf", {31'd0, unf}, 1);
        pulse(1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_clamp;
        mode = 2'b01; limit = 32'd3;
        ups(3);
        check("R4 reach top", count, 3);
        check("R4 no ovf yet", {31'd0, ovf}, 0);
        pulse(1'b1, 1'b0, 1'b0);
        check("R4 hold top", count, 3);
        check("R4 ovf", {31'd0, ovf}, 1);
        pulse(1'b1, 1'b0, 1'b0);
        check("R4 still held", count, 3);
        pulse(1'b1, 1'b1, 1'b0);
        check("R5 resume down", count, 2);
        pulse(1'b1, 1'b1, 1'b0);
        pulse(1'b1, 1'b1, 1'b0);
        pulse(1'b1, 1'b1, 1'b0);
        check("R4 hold zero", count, 0);
        check("R4 unf", {31'd0, unf}, 1);
        pulse(1'b1, 1'b1, 1'b0);
        check("R4 zero held", count, 0);
        pulse(1'b1, 1'b0, 1'b0);
        check("R5 resume up", count, 1);
        check("R1 enable in clamp", {31'd0, en}, 1);
        pulse(1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_oneshot;
        mode = 2'b10; limit = 32'd4;
        ups(3);
        check("R6 below limit enabled", {31'd0, en}, 1);
        pulse(1'b1, 1'b0, 1'b0);
        check("R6 limit count", count, 4);
        check("R6 disabled", {31'd0, en}, 0);
        pulse(1'b1, 1'b0, 1'b0);
        check("R6 up ignored", count, 4);
        pulse(1'b1, 1'b1, 1'b0);
        check("R6 down ignored", count, 4);
        pulse(1'b0, 1'b0, 1'b1);
        check("R8 re-enable", {31'd0, en}, 1);
        check("R8 count zero", count, 0);
        pulse(1'b1, 1'b1, 1'b0);
        check("R7 count", count, 0);
        check("R7 unf", {31'd0, unf}, 1);
        check("R7 disabled", {31'd0, en}, 0);
        pulse(1'b1, 1'b0, 1'b0);
        check("R7 up ignored", count, 0);
        pulse(1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_full;
        mode = 2'b00; limit = 32'd0; narrow = 1'b0;
        pulse(1'b1, 1'b1, 1'b0);
        check("R10 full scale down", count, 32'hFFFF_FFFF);
        pulse(1'b1, 1'b0, 1'b0);
        check("R10 full scale up", count, 0);
        check("R10 ovf", {31'd0, ovf}, 1);
        pulse(1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_narrow;
        narrow = 1'b1; limit = 32'd0;
        pulse(1'b1, 1'b1, 1'b0);
        check("R11 narrow full scale", count, 32'h0000_FFFF);
        pulse(1'b1, 1'b0, 1'b0);
        check("R11 narrow wrap", count, 0);
        check("R11 narrow ovf", {31'd0, ovf}, 1);
        limit = 32'h0001_2345;
        pulse(1'b0, 1'b0, 1'b1);
        pulse(1'b1, 1'b1, 1'b0);
        check("R11 limit masked", count, 32'h0000_2345);
        pulse(1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_wrap();
        t_clamp();
        t_oneshot();
        t_full();
        t_narrow();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule